// File: doc/BRIEF.md
# Manchester Bit Receiver with Interval Checking

This block turns a sliced, demodulated serial line into bytes. It samples the line only on cycles where a sample tick is high. It times every transition with a saturating tick counter and sorts each interval into one of two classes: a single half-bit spacing or a double spacing. Each class has its own programmable lower and upper bound.

While searching, the block waits for a preamble of identical Manchester bits. The first double-spacing interval after a long enough preamble marks the start bit, which always has the opposite value to the preamble. The start bit is also the most significant bit of the first byte. From there, bits are shifted in most significant bit first. Each completed byte appears on the output with a one-cycle valid strobe.

Any interval that fits neither class ends the frame with a one-cycle error pulse. So does a silence longer than the double-spacing maximum, and so does a missing mid-bit transition. After an error, the bits collected so far are dropped and the receiver goes back to searching for a preamble.

Top module: `manchester_rx`

## Requirements
- R1: After a synchronous reset, byte_valid, bit_err, err_logic and byte_data are all zero and the receiver is searching for a preamble.
- R2: A start bit is accepted only after at least PRE_BITS (default 4) identical preamble bits, that is at least 2*PRE_BITS-1 consecutive single-spacing intervals. A double-spacing interval after a shorter run is ignored: no byte and no error follow.
- R3: The first double-spacing interval after a qualifying run is taken as the start bit. The start bit's value is opposite to the preamble value, for either preamble polarity. The start bit becomes bit 7 of the first byte.
- R4: A bit's value is the line level after its mid-bit transition, so 1 is sent low-then-high and 0 is sent high-then-low. Bytes are assembled most significant bit first. Each byte is presented on byte_data with byte_valid high for exactly one cycle.
- R5: An interval of n ticks counts as single spacing when t_min <= n <= t_max. Otherwise it counts as double spacing when t2_min <= n <= t2_max. Intervals that vary anywhere inside these windows decode without error.
- R6: During reception, an interval outside both windows raises bit_err for one cycle with err_logic = 0. This covers intervals that are too short, too long, or between the two windows.
- R7: During reception, if no transition arrives within t2_max ticks of the last one, the result is a timing error (bit_err with err_logic = 0). This also ends every frame.
- R8: During reception, a double-spacing interval that follows a bit-boundary transition means the mid-bit transition is missing. It raises bit_err for one cycle with err_logic = 1.
- R9: After any error, the partly assembled byte is discarded and never presented. The receiver needs a fresh preamble before it accepts data again. byte_valid and bit_err are never high in the same cycle.
- R10: The line is sampled, and intervals advance, only on cycles where tick is high. A line glitch that starts and ends between two ticks has no effect.
- R11: The interval counter saturates at 2^CNT_W-1. An idle period longer than the counter range never looks like a valid interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample enable; one interval unit per high cycle |
| din | input | 1 | Sliced demodulated line |
| t_min | input | CNT_W | Single-spacing lower bound in ticks |
| t_max | input | CNT_W | Single-spacing upper bound in ticks |
| t2_min | input | CNT_W | Double-spacing lower bound in ticks |
| t2_max | input | CNT_W | Double-spacing upper bound and silence limit in ticks |
| byte_data | output | BYTE_W | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| bit_err | output | 1 | One-cycle bit error pulse |
| err_logic | output | 1 | With bit_err: 1 for a missing mid-bit transition, 0 for a timing error |

## Verification
The bench targets several corner cases.

- **Preamble length.** A preamble exactly at the minimum must be accepted, and one a bit shorter must be ignored. A design that counts intervals wrongly would either lose valid frames or lock onto data.
- **Error kinds.** Errors are injected in the middle of a byte, using a too-short interval, an interval between the windows, and a missing mid-bit transition. A design that keeps the partial bits would misalign the bytes of the next frame. A design that confuses the error kinds would report the wrong err_logic.
- **Glitches and jitter.** Glitches placed between ticks, and halves that wander inside the windows, catch a design that samples every clock or uses exact timing.
- **Long silence.** An idle of exactly counter range plus one half-bit catches a counter that wraps instead of saturating. Such a counter would see a phantom short interval and accept a preamble that is one interval too short.

// File: rtl/mrx_pkg.sv
// Shared types for the Manchester receiver.
package mrx_pkg;

    // Class of a measured edge-to-edge interval.
    typedef enum logic [1:0] {
        IV_SHORT = 2'd0,
        IV_LONG  = 2'd1,
        IV_BAD   = 2'd2
    } ivl_class_t;

    // Receiver phase: searching for preamble, or inside a frame.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_t;

endpackage

// File: rtl/mrx_edge_timer.sv
// mrx_edge_timer
// Samples the line on tick cycles, flags transitions, and measures the
// number of ticks since the previous transition with a saturating counter.
// Each transition is classified against the single- and double-spacing
// windows; single spacing wins if the windows overlap.
// Assumes din is already synchronous to clk.
module mrx_edge_timer
    import mrx_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] t_min,
    input  logic [CNT_W-1:0] t_max,
    input  logic [CNT_W-1:0] t2_min,
    input  logic [CNT_W-1:0] t2_max,
    output logic             edge_stb,
    output logic             edge_level,
    output ivl_class_t       ivl_class,
    output logic             timeout
);
    localparam int               NWIN    = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             din_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] win_lo [NWIN];
    logic [CNT_W-1:0] win_hi [NWIN];
    logic [NWIN-1:0]  in_win;

    assign win_lo[0] = t_min;
    assign win_hi[0] = t_max;
    assign win_lo[1] = t2_min;
    assign win_hi[1] = t2_max;

    // One window comparator per interval class.
    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            assign in_win[w] = (cnt >= win_lo[w]) && (cnt <= win_hi[w]);
        end
    endgenerate

    // Transition seen on a sample tick; the new level is the current input.
    assign edge_stb   = tick && (din != din_q);
    assign edge_level = din;

    // Silence beyond the double-spacing limit, seen on a tick without an edge.
    assign timeout = tick && !edge_stb && (cnt >= t2_max);

    // Classify the interval that ends with the current edge.
    always_comb begin
        if (in_win[0])      ivl_class = IV_SHORT;
        else if (in_win[1]) ivl_class = IV_LONG;
        else                ivl_class = IV_BAD;
    end

    // Track the sampled level and the saturating tick count since the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= 1'b0;
            cnt   <= CNT_MAX;
        end else if (tick) begin
            din_q <= din;
            if (edge_stb)           cnt <= CNT_ONE;
            else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !edge_stb && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R11

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(din_q))); // R10

endmodule

// File: rtl/mrx_sync_fsm.sv
// mrx_sync_fsm
// Preamble search and Manchester phase tracking. In search, it counts
// consecutive single-spacing intervals; a double-spacing interval after
// enough of them is the start bit. In a frame, it tracks whether the last
// edge was mid-bit and emits one bit strobe per mid-bit edge. It raises
// errors for bad intervals, silence and missing mid-bit edges, then
// returns to search.
// Assumes the classification inputs are valid in the cycle of edge_stb.
module mrx_sync_fsm
    import mrx_pkg::*;
#(
    parameter int PRE_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_stb,
    input  logic       edge_level,
    input  ivl_class_t ivl_class,
    input  logic       timeout,
    output logic       bit_stb,
    output logic       bit_val,
    output logic       err_stb,
    output logic       bit_err,
    output logic       err_logic,
    output logic       in_data
);
    localparam int               RUN_NEED = 2 * PRE_BITS - 1;
    localparam int               RUN_W    = $clog2(RUN_NEED + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_NEED);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    rx_state_t        state, state_n;
    logic             at_mid, at_mid_n;
    logic [RUN_W-1:0] run, run_n;
    logic             err_is_logic;

    // Next-state, bit strobe and error decisions for the current tick.
    always_comb begin
        state_n      = state;
        at_mid_n     = at_mid;
        run_n        = run;
        bit_stb      = 1'b0;
        bit_val      = edge_level;
        err_stb      = 1'b0;
        err_is_logic = 1'b0;
        case (state)
            ST_HUNT: begin
                if (edge_stb) begin
                    if (ivl_class == IV_SHORT) begin
                        run_n = (run == RUN_FULL) ? run : run + RUN_ONE;
                    end else if (ivl_class == IV_LONG && run == RUN_FULL) begin
                        state_n  = ST_DATA;
                        bit_stb  = 1'b1;
                        at_mid_n = 1'b1;
                        run_n    = '0;
                    end else begin
                        run_n = '0;
                    end
                end
            end
            default: begin
                if (timeout) begin
                    err_stb = 1'b1;
                end else if (edge_stb) begin
                    case (ivl_class)
                        IV_SHORT: begin
                            if (at_mid) begin
                                at_mid_n = 1'b0;
                            end else begin
                                bit_stb  = 1'b1;
                                at_mid_n = 1'b1;
                            end
                        end
                        IV_LONG: begin
                            if (at_mid) begin
                                bit_stb = 1'b1;
                            end else begin
                                err_stb      = 1'b1;
                                err_is_logic = 1'b1;
                            end
                        end
                        default: err_stb = 1'b1;
                    endcase
                end
                if (err_stb) begin
                    state_n  = ST_HUNT;
                    at_mid_n = 1'b0;
                    run_n    = '0;
                end
            end
        endcase
    end

    // Register the phase, preamble run and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            at_mid    <= 1'b0;
            run       <= '0;
            bit_err   <= 1'b0;
            err_logic <= 1'b0;
        end else begin
            state     <= state_n;
            at_mid    <= at_mid_n;
            run       <= run_n;
            bit_err   <= err_stb;
            err_logic <= err_stb && err_is_logic;
        end
    end

    assign in_data = (state == ST_DATA);

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |=> !bit_err); // R9

    AST_ERR_BACK_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> !in_data); // R9

    AST_BIT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> edge_stb); // R4

    AST_HUNT_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && !$past(in_data)) |-> !bit_err); // R6

endmodule

// File: rtl/mrx_byte_asm.sv
// mrx_byte_asm
// Shifts decoded bits in MSB first and presents each full byte with a
// one-cycle valid strobe. A drop request clears the partial byte.
// Assumes bit_stb and drop never occur together.
module mrx_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              drop,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int                BCNT_W = $clog2(BYTE_W);
    localparam logic [BCNT_W-1:0] LAST   = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] B_ONE  = BCNT_W'(1);

    logic [BCNT_W-1:0] bcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_n;

    assign shreg_n = {shreg[BYTE_W-2:0], bit_val};

    // Accumulate bits, publish full bytes, discard partial bytes on drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt       <= '0;
            shreg      <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (drop) begin
                bcnt <= '0;
            end else if (bit_stb) begin
                shreg <= shreg_n;
                if (bcnt == LAST) begin
                    byte_data  <= shreg_n;
                    byte_valid <= 1'b1;
                    bcnt       <= '0;
                end else begin
                    bcnt <= bcnt + B_ONE;
                end
            end
        end
    end

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= LAST); // R4

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (bcnt == '0 && !byte_valid)); // R9

endmodule

// File: rtl/manchester_rx.sv
// manchester_rx
// Top level of the Manchester receiver: interval timer, sync/phase FSM and
// byte assembler. The limit windows are static configuration inputs.
// Assumes the windows do not overlap and t2_max < 2^CNT_W-1.
module manchester_rx #(
    parameter int CNT_W    = 10,
    parameter int PRE_BITS = 4,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              din,
    input  logic [CNT_W-1:0]  t_min,
    input  logic [CNT_W-1:0]  t_max,
    input  logic [CNT_W-1:0]  t2_min,
    input  logic [CNT_W-1:0]  t2_max,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              bit_err,
    output logic              err_logic
);
    import mrx_pkg::*;

    logic       edge_stb;
    logic       edge_level;
    ivl_class_t ivl_class;
    logic       timeout;
    logic       bit_stb;
    logic       bit_val;
    logic       err_stb;
    logic       in_data;

    mrx_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .din        (din),
        .t_min      (t_min),
        .t_max      (t_max),
        .t2_min     (t2_min),
        .t2_max     (t2_max),
        .edge_stb   (edge_stb),
        .edge_level (edge_level),
        .ivl_class  (ivl_class),
        .timeout    (timeout)
    );

    mrx_sync_fsm #(.PRE_BITS(PRE_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_stb   (edge_stb),
        .edge_level (edge_level),
        .ivl_class  (ivl_class),
        .timeout    (timeout),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .err_stb    (err_stb),
        .bit_err    (bit_err),
        .err_logic  (err_logic),
        .in_data    (in_data)
    );

    mrx_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .drop       (err_stb),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

    AST_VALID_NOT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && bit_err)); // R9

    AST_BYTE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> in_data); // R2

    AST_LOGIC_ONLY_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_logic |-> bit_err); // R8

endmodule

// File: tb/tb_manchester_rx.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected bytes and errors, and a
// monitor pops and compares them as the receiver produces them.
module tb_manchester_rx;
    localparam int CNT_W  = 10;
    localparam int BYTE_W = 8;
    localparam int NOM    = 8;   // nominal half-bit in ticks

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              din = 1'b0;
    logic [CNT_W-1:0]  t_min  = 10'd6;
    logic [CNT_W-1:0]  t_max  = 10'd10;
    logic [CNT_W-1:0]  t2_min = 10'd14;
    logic [CNT_W-1:0]  t2_max = 10'd18;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_valid;
    logic              bit_err;
    logic              err_logic;

    int checks = 0;
    int fails  = 0;
    int cur_req = 2;
    bit done = 1'b0;

    // item: [9] error, [8] logical kind, [7:0] byte
    logic [9:0] exp_q[$];
    int         req_q[$];

    always #2.5 clk = ~clk;

    manchester_rx dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(din),
        .t_min(t_min), .t_max(t_max), .t2_min(t2_min), .t2_max(t2_max),
        .byte_data(byte_data), .byte_valid(byte_valid),
        .bit_err(bit_err), .err_logic(err_logic)
    );

    task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input int req);
        exp_q.push_back({2'b00, v});
        req_q.push_back(req);
    endtask

    task automatic expect_err(input logic lg, input int req);
        exp_q.push_back({1'b1, lg, 8'h00});
        req_q.push_back(req);
    endtask

    // Hold a level for n ticks; a tick every second cycle. With glitch set,
    // the line flips during the off cycle of the first tick (R10).
    task automatic seg(input logic lvl, input int n, input bit glitch);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); din = lvl; tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (glitch && i == 0) din = ~lvl;
        end
        din = lvl;
    endtask

    task automatic send_bit(input logic b, input int h1, input int h2, input bit g);
        seg(~b, h1, 1'b0);
        seg(b, h2, g);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit jit, input bit g);
        for (int i = 7; i >= 0; i--) begin
            if (jit) send_bit(v[i], 7 + (i % 3), 7 + ((i + 1) % 3), g);
            else     send_bit(v[i], NOM, NOM, g);
        end
    endtask

    // Idle at the preamble level, then n preamble bits of value p.
    task automatic start_frame(input logic p, input int n);
        seg(p, 40, 1'b0);
        for (int i = 0; i < n; i++) send_bit(p, NOM, NOM, 1'b0);
    endtask

    task automatic idle_tail();
        seg(din, 40, 1'b0);
    endtask

    // One full byte, three more bits, then a corrupted bit whose first half is h1.
    task automatic err_frame(input int h1, input logic lg, input int req);
        start_frame(1'b0, 4);
        expect_byte(8'hB2, 9);
        send_byte(8'hB2, 1'b0, 1'b0);
        send_bit(1'b1, NOM, NOM, 1'b0);
        send_bit(1'b0, NOM, NOM, 1'b0);
        send_bit(1'b0, NOM, NOM, 1'b0);
        expect_err(lg, req);
        send_bit(1'b0, h1, NOM, 1'b0);
        idle_tail();
    endtask

    // Monitor: compare every strobe with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (byte_valid || bit_err)) begin
            logic [9:0] got;
            got = bit_err ? {1'b1, err_logic, 8'h00} : {2'b00, byte_data};
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R%0d: unexpected output %h, expected none", cur_req, got);
            end else begin
                logic [9:0] e;
                int r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, got, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        // R1: reset state
        check(1, {9'b0, byte_valid}, 10'd0);
        check(1, {9'b0, bit_err}, 10'd0);
        check(1, {9'b0, err_logic}, 10'd0);
        check(1, {2'b0, byte_data}, 10'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R7: zero preamble at the minimum length (R2), nominal timing
        cur_req = 2;
        expect_byte(8'hA5, 3);
        expect_byte(8'h3C, 4);
        expect_byte(8'hFF, 4);
        expect_byte(8'h00, 4);
        expect_err(1'b0, 7);
        start_frame(1'b0, 4);
        send_byte(8'hA5, 1'b0, 1'b0);
        send_byte(8'h3C, 1'b0, 1'b0);
        send_byte(8'hFF, 1'b0, 1'b0);
        send_byte(8'h00, 1'b0, 1'b0);
        idle_tail();

        // R3: ones preamble, start bit 0
        expect_byte(8'h5A, 3);
        expect_byte(8'hC3, 4);
        expect_err(1'b0, 7);
        start_frame(1'b1, 6);
        send_byte(8'h5A, 1'b0, 1'b0);
        send_byte(8'hC3, 1'b0, 1'b0);
        idle_tail();

        // R5: halves jitter between 7 and 9 ticks
        expect_byte(8'h96, 5);
        expect_byte(8'h0F, 5);
        expect_err(1'b0, 7);
        start_frame(1'b0, 5);
        send_byte(8'h96, 1'b1, 1'b0);
        send_byte(8'h0F, 1'b1, 1'b0);
        idle_tail();

        // R2: preamble one bit short, nothing may come out
        cur_req = 2;
        start_frame(1'b0, 3);
        send_byte(8'hAA, 1'b0, 1'b0);
        idle_tail();

        // R10: glitches between ticks are ignored
        cur_req = 10;
        expect_byte(8'h6B, 10);
        expect_byte(8'h91, 10);
        expect_err(1'b0, 7);
        start_frame(1'b1, 4);
        send_byte(8'h6B, 1'b0, 1'b1);
        send_byte(8'h91, 1'b0, 1'b1);
        idle_tail();

        // R6: too short, then between the windows; R8: missing mid-bit edge
        cur_req = 6;
        err_frame(3, 1'b0, 6);
        err_frame(12, 1'b0, 6);
        cur_req = 8;
        err_frame(16, 1'b1, 8);

        // R9: recovery after a dropped partial byte
        cur_req = 9;
        expect_byte(8'h7E, 9);
        expect_byte(8'h81, 9);
        expect_err(1'b0, 7);
        start_frame(1'b1, 4);
        send_byte(8'h7E, 1'b0, 1'b0);
        send_byte(8'h81, 1'b0, 1'b0);
        idle_tail();

        // R11: idle of counter range plus one half-bit, then a short preamble
        cur_req = 11;
        seg(1'b0, 40, 1'b0);
        seg(1'b1, 1024, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b0, NOM, NOM, 1'b0);
        send_byte(8'hAA, 1'b0, 1'b0);
        idle_tail();

        repeat (20) @(negedge clk);
        // R9: every expected item has been seen
        check(9, 10'(exp_q.size()), 10'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule